// File: doc/BRIEF.md
# Wishbone to 16-bit Asynchronous Handshake Bus Bridge

This bridge lets a soft processor core with a 32-bit Wishbone master port reach external RAM, PROM and I/O devices. Those devices sit on a 16-bit asynchronous bus that keeps the legacy pin-out: an address strobe, upper and lower data strobes, a read/write line and an active-low transfer acknowledge. A Wishbone read or write becomes one or two external handshake cycles, and the core receives ACK once all of them have finished. A full 32-bit transfer is split into two back-to-back 16-bit cycles. The upper half goes first, at the even word address. The lower half follows at the next word address.

The external cycle does not have a fixed length. It ends when the peripheral pulls the acknowledge low. That input is synchronised to the fast clock before the bridge acts on it. The bridge drives the address and direction first, then waits a programmable number of fast-clock ticks (`OUT_DLY`) before it asserts the strobes and drives write data. This delay stands in for the slower clock-to-output time of the part being replaced. A watchdog counter (`TMO_CYC`) ends any cycle that never receives an acknowledge and returns a Wishbone error.

The data pins are carried as separate out, enable and in vectors, and the pad ring joins them into a tri-state bus.

Top module: `wb_legacy_bridge`

## Requirements
- R1: After reset, the address strobe and both data strobes are high, the read/write line is high (read), the data output enable is low, and ACK and ERR are low.
- R2: A read with all four byte selects runs two external read cycles. The first is at word address {adr[AW-1:2],0}, and its data returns on wb_dat_o[31:16]. The second is at {adr[AW-1:2],1}, and its data returns on wb_dat_o[15:0]. ACK follows the second cycle.
- R3: A write with all four byte selects runs two external write cycles with the read/write line low. wb_dat_i[31:16] is written at the even word and wb_dat_i[15:0] at the odd word.
- R4: sel[3] and sel[1] drive the upper data strobe (external bits 15:8). sel[2] and sel[0] drive the lower data strobe (bits 7:0). If only sel[3:2] is non-zero, a single cycle runs at the even word. If only sel[1:0] is non-zero, a single cycle runs at the odd word. On a read, the half that is not accessed returns zero.
- R5: A request with all byte selects zero is acknowledged in the clock after it is sampled, with no external cycle and read data of zero.
- R6: The strobes assert exactly OUT_DLY clocks after the address and read/write line are driven. On a write, the data output enable rises on the same clock edge as the strobes.
- R7: Each external cycle holds its strobes until the synchronised acknowledge is seen, for however long that takes within the timeout. Read data is captured in the clock that sees the acknowledge.
- R8: The data output enable is high only while the strobes are asserted during a write. It falls one clock before the strobes are negated.
- R9: After the strobes are negated, neither the next external cycle nor the Wishbone response begins until the acknowledge has returned high.
- R10: If no acknowledge is seen within TMO_CYC clocks of strobe assertion, the strobes are negated and ERR is returned instead of ACK. The second half of a 32-bit transfer is not started.
- R11: If the acknowledge is recognised in the same clock that the timeout expires, the cycle completes normally with ACK.
- R12: ACK and ERR are single-clock pulses, are never high together, and are only given while CYC and STB are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc_i | input | 1 | Wishbone cycle |
| wb_stb_i | input | 1 | Wishbone strobe |
| wb_we_i | input | 1 | Wishbone write enable |
| wb_adr_i | input | AW | Wishbone byte address |
| wb_sel_i | input | 4 | Wishbone byte selects, bit 3 = bits 31:24 |
| wb_dat_i | input | 32 | Wishbone write data |
| wb_dat_o | output | 32 | Wishbone read data |
| wb_ack_o | output | 1 | Wishbone acknowledge |
| wb_err_o | output | 1 | Wishbone error (timeout) |
| ext_adr_o | output | AW-1 | External word address |
| ext_as_n_o | output | 1 | Address strobe, active low |
| ext_uds_n_o | output | 1 | Upper data strobe (bits 15:8), active low |
| ext_lds_n_o | output | 1 | Lower data strobe (bits 7:0), active low |
| ext_rw_o | output | 1 | 1 = read, 0 = write |
| ext_dat_o | output | 16 | External write data |
| ext_dat_oe_o | output | 1 | Drive enable for ext_dat_o |
| ext_dat_i | input | 16 | External read data |
| ext_dtack_n_i | input | 1 | Transfer acknowledge, active low, asynchronous |

## Verification
Two functions can decide in the same clock: the synchronised acknowledge arriving and the timeout counter expiring. The bench provokes this with a peripheral model that measures its response from the first clock of strobe assertion. One run releases the acknowledge so that it is recognised exactly on the expiry edge. A second run releases it one clock later. The first must end with ACK and a normal second half, and the second must end with ERR and only one external cycle recorded by the scoreboard.

// File: rtl/wlb_pkg.sv
package wlb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_RELEASE,
        ST_NEGATE,
        ST_DONE
    } wlb_state_e;

    // Which 16-bit halves a request touches and with which byte strobes
    typedef struct packed {
        logic       hi_use;
        logic       lo_use;
        logic [1:0] hi_ds;   // [1] upper strobe, [0] lower strobe
        logic [1:0] lo_ds;
    } wlb_plan_t;

    function automatic wlb_plan_t wlb_plan(input logic [3:0] sel);
        wlb_plan_t p;
        p.hi_ds  = sel[3:2];
        p.lo_ds  = sel[1:0];
        p.hi_use = |sel[3:2];
        p.lo_use = |sel[1:0];
        return p;
    endfunction

endpackage

// File: rtl/wlb_sync.sv
module wlb_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wlb_tick_counter.sv
module wlb_tick_counter #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)     cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign hit = en && (cnt == LAST);
endmodule

// File: rtl/wb_legacy_bridge.sv
module wb_legacy_bridge
    import wlb_pkg::*;
#(
    parameter int AW          = 24,
    parameter int OUT_DLY     = 7,
    parameter int TMO_CYC     = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wb_cyc_i,
    input  logic          wb_stb_i,
    input  logic          wb_we_i,
    input  logic [AW-1:0] wb_adr_i,
    input  logic [3:0]    wb_sel_i,
    input  logic [31:0]   wb_dat_i,
    output logic [31:0]   wb_dat_o,
    output logic          wb_ack_o,
    output logic          wb_err_o,
    output logic [AW-2:0] ext_adr_o,
    output logic          ext_as_n_o,
    output logic          ext_uds_n_o,
    output logic          ext_lds_n_o,
    output logic          ext_rw_o,
    output logic [15:0]   ext_dat_o,
    output logic          ext_dat_oe_o,
    input  logic [15:0]   ext_dat_i,
    input  logic          ext_dtack_n_i
);
    localparam int LW = AW - 2;

    wlb_state_e    st;
    wlb_plan_t     plan_q, req_plan;
    logic          on_hi, rd_q, fail_q;
    logic [LW-1:0] line_q;
    logic [31:0]   wdat_q;
    logic [1:0]    cur_ds;
    logic          dtk_n_s, dly_hit, tmo_hit;

    assign req_plan = wlb_plan(wb_sel_i);
    assign cur_ds   = on_hi ? plan_q.hi_ds : plan_q.lo_ds;

    wlb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_dtk_sync (
        .clk(clk), .rst(rst), .d(ext_dtack_n_i), .q(dtk_n_s)
    );

    wlb_tick_counter #(.LIMIT(OUT_DLY)) u_out_dly (
        .clk(clk), .rst(rst), .en(st == ST_SETUP), .hit(dly_hit)
    );

    wlb_tick_counter #(.LIMIT(TMO_CYC)) u_watchdog (
        .clk(clk), .rst(rst), .en(st == ST_STROBE), .hit(tmo_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= ST_IDLE;
            plan_q       <= '0;
            on_hi        <= 1'b0;
            rd_q         <= 1'b1;
            fail_q       <= 1'b0;
            line_q       <= '0;
            wdat_q       <= '0;
            wb_dat_o     <= '0;
            wb_ack_o     <= 1'b0;
            wb_err_o     <= 1'b0;
            ext_adr_o    <= '0;
            ext_as_n_o   <= 1'b1;
            ext_uds_n_o  <= 1'b1;
            ext_lds_n_o  <= 1'b1;
            ext_rw_o     <= 1'b1;
            ext_dat_o    <= '0;
            ext_dat_oe_o <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (wb_cyc_i && wb_stb_i) begin
                    plan_q   <= req_plan;
                    line_q   <= wb_adr_i[AW-1:2];
                    wdat_q   <= wb_dat_i;
                    rd_q     <= !wb_we_i;
                    fail_q   <= 1'b0;
                    wb_dat_o <= '0;
                    if (!req_plan.hi_use && !req_plan.lo_use) begin
                        wb_ack_o <= 1'b1;
                        st       <= ST_DONE;
                    end else begin
                        on_hi     <= req_plan.hi_use;
                        ext_adr_o <= {wb_adr_i[AW-1:2], !req_plan.hi_use};
                        ext_rw_o  <= !wb_we_i;
                        st        <= ST_SETUP;
                    end
                end
                ST_SETUP: if (dly_hit) begin
                    ext_as_n_o  <= 1'b0;
                    ext_uds_n_o <= !cur_ds[1];
                    ext_lds_n_o <= !cur_ds[0];
                    if (!rd_q) begin
                        ext_dat_oe_o <= 1'b1;
                        ext_dat_o    <= on_hi ? wdat_q[31:16] : wdat_q[15:0];
                    end
                    st <= ST_STROBE;
                end
                ST_STROBE: begin
                    if (!dtk_n_s) begin
                        if (rd_q) begin
                            if (on_hi) wb_dat_o[31:16] <= ext_dat_i;
                            else       wb_dat_o[15:0]  <= ext_dat_i;
                        end
                        ext_dat_oe_o <= 1'b0;
                        st           <= ST_RELEASE;
                    end else if (tmo_hit) begin
                        fail_q       <= 1'b1;
                        ext_dat_oe_o <= 1'b0;
                        st           <= ST_RELEASE;
                    end
                end
                ST_RELEASE: begin
                    ext_as_n_o  <= 1'b1;
                    ext_uds_n_o <= 1'b1;
                    ext_lds_n_o <= 1'b1;
                    st          <= ST_NEGATE;
                end
                ST_NEGATE: if (dtk_n_s) begin
                    if (fail_q) begin
                        wb_err_o <= 1'b1;
                        st       <= ST_DONE;
                    end else if (on_hi && plan_q.lo_use) begin
                        on_hi     <= 1'b0;
                        ext_adr_o <= {line_q, 1'b1};
                        st        <= ST_SETUP;
                    end else begin
                        wb_ack_o <= 1'b1;
                        st       <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    wb_ack_o <= 1'b0;
                    wb_err_o <= 1'b0;
                    ext_rw_o <= 1'b1;
                    st       <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // ---------------- assertions ----------------
    p_addr_held_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(ext_adr_o) |-> (ext_as_n_o && $past(ext_as_n_o)));

    p_ds_inside_as_r4: assert property (@(posedge clk) disable iff (rst)
        (!ext_uds_n_o || !ext_lds_n_o) |-> !ext_as_n_o);

    p_as_has_ds_r4: assert property (@(posedge clk) disable iff (rst)
        !ext_as_n_o |-> (!ext_uds_n_o || !ext_lds_n_o));

    p_oe_write_only_r8: assert property (@(posedge clk) disable iff (rst)
        ext_dat_oe_o |-> (!ext_as_n_o && !ext_rw_o));

    p_oe_off_first_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_as_n_o) |-> !$past(ext_dat_oe_o));

    p_ack_gone_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(ext_as_n_o) |-> dtk_n_s);

    p_resp_excl_r12: assert property (@(posedge clk) disable iff (rst)
        !(wb_ack_o && wb_err_o));

    p_resp_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        (wb_ack_o || wb_err_o) |=> !(wb_ack_o || wb_err_o));

    p_resp_in_req_r12: assert property (@(posedge clk) disable iff (rst)
        (wb_ack_o || wb_err_o) |-> (wb_cyc_i && wb_stb_i));

endmodule

// File: tb/wb_legacy_bridge_test.sv
module wb_legacy_bridge_test;
    localparam int AW  = 24;
    localparam int DLY = 3;
    localparam int TMO = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          cyc = 0, stb = 0, we = 0;
    logic [AW-1:0] adr = '0;
    logic [3:0]    sel = '0;
    logic [31:0]   wdat = '0;
    logic [31:0]   rdat;
    logic          ack, err;
    logic [AW-2:0] xadr;
    logic          as_n, uds_n, lds_n, rw, oe;
    logic [15:0]   dout;
    logic [15:0]   din = '0;
    logic          dtack_n = 1'b1;

    wb_legacy_bridge #(.AW(AW), .OUT_DLY(DLY), .TMO_CYC(TMO), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst),
        .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr),
        .wb_sel_i(sel), .wb_dat_i(wdat), .wb_dat_o(rdat),
        .wb_ack_o(ack), .wb_err_o(err),
        .ext_adr_o(xadr), .ext_as_n_o(as_n), .ext_uds_n_o(uds_n),
        .ext_lds_n_o(lds_n), .ext_rw_o(rw), .ext_dat_o(dout),
        .ext_dat_oe_o(oe), .ext_dat_i(din), .ext_dtack_n_i(dtack_n)
    );

    int tests = 0, fails = 0;
    int per_lat = 2;
    int rel_lat = 1;
    logic [15:0] pm [64];
    logic [15:0] sh [64];

    typedef struct {
        logic [AW-2:0] adr;
        logic          rd;
        logic          u;
        logic          l;
        logic [15:0]   wd;
        string         tag;
    } ext_item_t;
    ext_item_t exp_q[$];
    ext_item_t it;

    function automatic logic [15:0] seed_word(int i);
        return 16'(i * 771) ^ 16'h5AC3;
    endfunction

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // ---------------- scoreboard monitor ----------------
    logic prev_as = 1'b1, prev_oe = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_as && !as_n) begin
                check_eq("R9 acknowledge high at new strobe", 32'(dtack_n), 32'd1);
                if (exp_q.size() == 0) begin
                    check_eq("R5 unexpected external cycle", 32'd1, 32'd0);
                end else begin
                    it = exp_q.pop_front();
                    check_eq({it.tag, " address"}, 32'(xadr), 32'(it.adr));
                    check_eq({it.tag, " rw/uds/lds"}, {29'd0, rw, uds_n, lds_n},
                             {29'd0, it.rd, !it.u, !it.l});
                    if (!it.rd)
                        check_eq({it.tag, " R6 write data driven with strobe"},
                                 {15'd0, oe, dout}, {15'd0, 1'b1, it.wd});
                end
            end
            if (!prev_as && as_n)
                check_eq("R8 data released before strobe negation", 32'(prev_oe), 32'd0);
            prev_as = as_n;
            prev_oe = oe;
        end
    end

    // ---------------- peripheral model ----------------
    initial begin
        int idx;
        forever begin
            @(negedge clk);
            if (!rst && !as_n) begin
                idx = int'(xadr[5:0]);
                if (per_lat >= 0) begin
                    repeat (per_lat) @(negedge clk);
                    if (rw) din = pm[idx];
                    else begin
                        if (!uds_n) pm[idx][15:8] = dout[15:8];
                        if (!lds_n) pm[idx][7:0]  = dout[7:0];
                    end
                    dtack_n = 1'b0;
                end
                while (!as_n) @(negedge clk);
                repeat (rel_lat) @(negedge clk);
                dtack_n = 1'b1;
                din     = '0;
            end
        end
    end

    // ---------------- driver ----------------
    task automatic push_half(input logic [AW-2:0] wa, input bit rd, input logic [1:0] ds,
                             input logic [15:0] wd, input string tag);
        exp_q.push_back('{adr: wa, rd: rd, u: ds[1], l: ds[0], wd: wd, tag: tag});
    endtask

    task automatic wb_xfer(input bit w, input logic [AW-1:0] a, input logic [3:0] s,
                           input logic [31:0] d, input bit abort, input string tag,
                           output logic [31:0] q, output bit got_ack, output bit got_err,
                           output int as_lat);
        logic [AW-3:0] line;
        int hi, lo;
        line = a[AW-1:2];
        hi = int'({a[5:2], 1'b0});
        lo = int'({a[5:2], 1'b1});
        if (|s[3:2]) push_half({line, 1'b0}, !w, s[3:2], w ? d[31:16] : 16'h0, tag);
        if (|s[1:0] && !(abort && |s[3:2]))
            push_half({line, 1'b1}, !w, s[1:0], w ? d[15:0] : 16'h0, tag);
        if (w && !abort) begin
            if (s[3]) sh[hi][15:8] = d[31:24];
            if (s[2]) sh[hi][7:0]  = d[23:16];
            if (s[1]) sh[lo][15:8] = d[15:8];
            if (s[0]) sh[lo][7:0]  = d[7:0];
        end
        @(negedge clk);
        cyc = 1; stb = 1; we = w; adr = a; sel = s; wdat = d;
        as_lat = -1; got_ack = 0; got_err = 0;
        for (int n = 1; n <= 3000; n++) begin
            @(negedge clk);
            if (as_lat < 0 && !as_n) as_lat = n;
            if (ack || err) begin
                got_ack = ack;
                got_err = err;
                break;
            end
        end
        q = rdat;
        @(negedge clk);
        check_eq("R12 response is a single-clock pulse", {30'd0, ack, err}, 32'd0);
        cyc = 0; stb = 0; we = 0;
    endtask

    function automatic logic [31:0] rd32(logic [AW-1:0] a);
        return {sh[int'({a[5:2], 1'b0})], sh[int'({a[5:2], 1'b1})]};
    endfunction

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] q;
        bit ok, bad;
        int lat;
        for (int i = 0; i < 64; i++) begin
            pm[i] = seed_word(i);
            sh[i] = seed_word(i);
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check_eq("R1 reset pin state", {25'd0, as_n, uds_n, lds_n, rw, oe, ack, err},
                 {25'd0, 7'b1111000});

        // R2 full read, R6 delay
        wb_xfer(0, 24'h000008, 4'hF, 0, 0, "R2", q, ok, bad, lat);
        check_eq("R2 read data", q, rd32(24'h000008));
        check_eq("R2 ack", {30'd0, ok, bad}, 32'd2);
        check_eq("R6 strobe delay", 32'(lat), 32'(DLY + 1));

        // R3 full write and read back
        wb_xfer(1, 24'h000010, 4'hF, 32'hDEADBEEF, 0, "R3", q, ok, bad, lat);
        check_eq("R3 write ack", {30'd0, ok, bad}, 32'd2);
        check_eq("R6 write strobe delay", 32'(lat), 32'(DLY + 1));
        wb_xfer(0, 24'h000010, 4'hF, 0, 0, "R3", q, ok, bad, lat);
        check_eq("R3 read back", q, 32'hDEADBEEF);

        // R4 byte and half accesses
        wb_xfer(1, 24'h000020, 4'b0100, 32'h00AB0000, 0, "R4", q, ok, bad, lat);
        wb_xfer(1, 24'h000024, 4'b0001, 32'h000000C7, 0, "R4", q, ok, bad, lat);
        wb_xfer(0, 24'h000020, 4'b0011, 0, 0, "R4", q, ok, bad, lat);
        check_eq("R4 lower-half read", q, {16'h0, sh[17]});
        wb_xfer(0, 24'h000020, 4'b1000, 0, 0, "R4", q, ok, bad, lat);
        check_eq("R4 upper-half read", q, {sh[16], 16'h0});
        check_eq("R4 byte write landed", 32'(sh[16][7:0]), 32'h000000AB);
        wb_xfer(0, 24'h000024, 4'b0011, 0, 0, "R4", q, ok, bad, lat);
        check_eq("R4 byte write lower half", q, {16'h0, sh[19]});

        // R5 empty selects
        wb_xfer(0, 24'h000030, 4'b0000, 0, 0, "R5", q, ok, bad, lat);
        check_eq("R5 ack without cycle", {30'd0, ok, bad}, 32'd2);
        check_eq("R5 no strobe", 32'(lat), 32'hFFFFFFFF);
        check_eq("R5 data zero", q, 32'd0);

        // R7 slow peripheral
        per_lat = 15;
        wb_xfer(0, 24'h000004, 4'hF, 0, 0, "R7", q, ok, bad, lat);
        check_eq("R7 slow read data", q, rd32(24'h000004));
        check_eq("R7 slow read ack", {30'd0, ok, bad}, 32'd2);
        per_lat = 2;

        // R9 late acknowledge release
        rel_lat = 6;
        wb_xfer(0, 24'h00000C, 4'hF, 0, 0, "R9", q, ok, bad, lat);
        check_eq("R9 read data", q, rd32(24'h00000C));
        rel_lat = 1;

        // R10 timeout
        per_lat = -1;
        wb_xfer(0, 24'h000014, 4'hF, 0, 1, "R10", q, ok, bad, lat);
        check_eq("R10 error instead of ack", {30'd0, ok, bad}, 32'd1);
        per_lat = 2;
        wb_xfer(0, 24'h000014, 4'hF, 0, 0, "R10", q, ok, bad, lat);
        check_eq("R10 recovery after error", q, rd32(24'h000014));

        // R11 acknowledge on the expiry edge, then one clock late
        per_lat = TMO - 3;
        wb_xfer(0, 24'h000018, 4'hF, 0, 0, "R11", q, ok, bad, lat);
        check_eq("R11 ack wins on expiry edge", {30'd0, ok, bad}, 32'd2);
        check_eq("R11 data", q, rd32(24'h000018));
        per_lat = TMO - 2;
        wb_xfer(0, 24'h00001C, 4'hF, 0, 1, "R11", q, ok, bad, lat);
        check_eq("R11 one clock late gives error", {30'd0, ok, bad}, 32'd1);
        per_lat = 2;

        repeat (20) @(negedge clk);
        check_eq("R10 no expected cycle left over", 32'(exp_q.size()), 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule